// File: doc/BRIEF.md
# Receive byte clock generator with reframe stretching

This block sits behind a serial receiver's clock recovery. On every recovered bit clock edge it takes one bit from one of two serial inputs, shifts it into a character register and advances a bit index. Once per character it copies the complete character into a decode register and raises a one-bit-time transfer strobe. It also derives the byte-rate output clock from the same index.

When the framer finds a comma, it asserts a reframe request. The bit sampled in that cycle becomes bit zero of a new character, and the bit index restarts there at once, so data alignment is never delayed. The byte clock cannot follow the jump blindly. It moves only at two kinds of points: a rising point where the index restarts, and a falling point half a character later. At either point it changes level only if its current phase has already lasted its normal length. Otherwise it holds its level until a later point. As a result a reframe can lengthen a high phase or a low phase, but no phase is ever shortened. The character that the reframe cuts short never produces a strobe.

The character length is `BITS`. The high phase lasts `HI = (BITS+1)/2` bit times and the low phase lasts `LO = BITS - HI` bit times.

Top module: `rx_byte_clk`

## Requirements
- R1: The sampled serial bit comes from `ser_a` when `sel_a` is 1 and from `ser_b` when `sel_a` is 0.
- R2: While `rst_n` is low, `byte_clk`, `xfer_stb` and `dec_q` are 0. The first rising edge after reset occurs at the first bit clock edge, and that edge samples bit zero of the first character.
- R3: The bits are counted by index 0 to BITS-1. At the edge that samples index BITS-1, `dec_q` loads the whole character with the first-received bit in the MSB. `xfer_stb` is high for exactly the one bit time that follows that edge.
- R4: With no reframe, `byte_clk` is high in the bit times after the edges that sample indices 0 to HI-1 and low for the rest. It rises on the edge that ends the `xfer_stb` pulse.
- R5: The bit sampled while `reframe` is high becomes index 0 of a new character. The next transfer follows BITS-1 edges later and carries that character.
- R6: A reframe on the edge where index BITS-1 would have been sampled produces no transfer strobe for the interrupted character.
- R7: Every high phase lasts at least HI bit times, every low phase lasts at least LO bit times, and every period lasts at least BITS bit times.
- R8: A reframe while the high phase has lasted j bit times (1 ≤ j ≤ HI) makes that high phase last j+HI bit times. The following low phase is normal.
- R9: A reframe while the low phase has lasted j < LO bit times makes that low phase last j+BITS bit times. No period exceeds 2·BITS-1 bit times.
- R10: A reframe when the low phase has lasted exactly LO bit times leaves the byte clock waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_a | input | 1 | Serial input A |
| ser_b | input | 1 | Serial input B |
| sel_a | input | 1 | 1 selects A, 0 selects B |
| reframe | input | 1 | Framer request; the current bit starts a new character |
| dec_q | output | BITS | Decode register |
| xfer_stb | output | 1 | One-bit-time strobe marking a fresh `dec_q` |
| byte_clk | output | 1 | Byte-rate output clock |

## Verification
The bench builds the block with the default `BITS = 10`, so both phases are 5 bit times long. This reaches the longest legal low phase of 14 bit times and the 19-bit-time period that comes with it. It also exercises a stretched 8-bit-time high phase and a reframe that lands exactly on a regular rising point. A further reframe lands where the strobe was due, so the suppression case is covered as well as the undisturbed case.

// File: rtl/rx_byte_clk.sv
module rx_byte_clk #(
  parameter int BITS = 10
) (
  input  logic            bit_clk,
  input  logic            rst_n,
  input  logic            ser_a,
  input  logic            ser_b,
  input  logic            sel_a,
  input  logic            reframe,
  output logic [BITS-1:0] dec_q,
  output logic            xfer_stb,
  output logic            byte_clk
);
  localparam int HI   = (BITS + 1) / 2;
  localparam int LO   = BITS - HI;
  localparam int CW   = $clog2(BITS);
  localparam int PMAX = (HI > LO) ? HI : LO;
  localparam int PW   = $clog2(PMAX + 1);

  logic            din;
  logic [BITS-1:0] sh;
  logic [BITS-1:0] word;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   idx;
  logic [PW-1:0]   plen;
  logic            last_bit;
  logic            rise_pt;
  logic            fall_pt;

  assign din      = sel_a ? ser_a : ser_b;
  assign word     = {sh[BITS-2:0], din};
  assign idx      = (reframe || cnt == CW'(BITS - 1)) ? '0 : cnt + 1'b1;
  assign last_bit = (idx == CW'(BITS - 1));
  assign rise_pt  = !byte_clk && (idx == '0)      && (plen >= PW'(LO));
  assign fall_pt  =  byte_clk && (idx == CW'(HI)) && (plen >= PW'(HI));

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= CW'(BITS - 1);
      dec_q    <= '0;
      xfer_stb <= 1'b0;
      byte_clk <= 1'b0;
      plen     <= PW'(LO);
    end else begin
      sh       <= word;
      cnt      <= idx;
      xfer_stb <= last_bit;
      if (last_bit)
        dec_q <= word;
      if (rise_pt || fall_pt) begin
        byte_clk <= ~byte_clk;
        plen     <= PW'(1);
      end else if (plen != PW'(PMAX)) begin
        plen <= plen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_byte_clk_chk.sv
module rx_byte_clk_chk #(
  parameter int BITS = 10
) (
  input logic bit_clk,
  input logic rst_n,
  input logic reframe,
  input logic xfer_stb,
  input logic byte_clk
);
  localparam int HI = (BITS + 1) / 2;
  localparam int LO = BITS - HI;
  localparam int RW = $clog2(2 * BITS + 1) + 1;

  logic          lvl_q;
  logic          started;
  logic          hi_seen;
  logic [RW-1:0] run;
  logic [RW-1:0] hi_last;
  logic          chg;
  logic [RW:0]   prd;

  assign chg = (byte_clk != lvl_q);
  assign prd = {1'b0, run} + {1'b0, hi_last};

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      started <= 1'b0;
      hi_seen <= 1'b0;
      run     <= '0;
      hi_last <= '0;
    end else begin
      lvl_q <= byte_clk;
      if (chg) begin
        run     <= RW'(1);
        started <= 1'b1;
        if (lvl_q) begin
          hi_last <= run;
          hi_seen <= started;
        end
      end else if (run != '1) begin
        run <= run + 1'b1;
      end
    end
  end

  // R7
  hi_short_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (started && chg && lvl_q) |-> (run >= RW'(HI)));

  // R7
  lo_short_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (started && chg && !lvl_q) |-> (run >= RW'(LO)));

  // R7
  prd_short_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (hi_seen && chg && !lvl_q) |-> (prd >= (RW+1)'(BITS)));

  // R9
  prd_long_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (hi_seen && chg && !lvl_q) |-> (prd <= (RW+1)'(2 * BITS - 1)));

  // R3
  stb_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    xfer_stb |=> !xfer_stb);

  // R4
  stb_rise_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    xfer_stb |=> $rose(byte_clk));

  // R6
  rf_nostb_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    reframe |=> !xfer_stb);
endmodule

bind rx_byte_clk rx_byte_clk_chk #(.BITS(BITS)) u_chk (
  .bit_clk  (bit_clk),
  .rst_n    (rst_n),
  .reframe  (reframe),
  .xfer_stb (xfer_stb),
  .byte_clk (byte_clk)
);

// File: tb/sim_rx_byte_clk.sv
module sim_rx_byte_clk;
  localparam int BITS = 10;
  localparam int HI   = 5;
  localparam int LO   = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ser_a, ser_b, sel_a, reframe;
  logic [BITS-1:0] dec_q;
  logic            xfer_stb, byte_clk;

  int tests = 0;
  int fails = 0;

  int run = 0, last_hi = 0, last_lo = 0;
  int min_hi = 1000, min_lo = 1000, min_prd = 1000, max_prd = 0;
  bit started = 0, have_hi = 0;
  logic prev = 1'b0;

  rx_byte_clk #(.BITS(BITS)) u0 (
    .bit_clk(clk), .rst_n(rst_n), .ser_a(ser_a), .ser_b(ser_b),
    .sel_a(sel_a), .reframe(reframe), .dec_q(dec_q),
    .xfer_stb(xfer_stb), .byte_clk(byte_clk)
  );

  always #4 clk = ~clk;

  // phase-length monitor, sampled 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      run = 0; started = 0; have_hi = 0; prev = 1'b0;
    end else if (byte_clk !== prev) begin
      if (started) begin
        if (prev) begin
          last_hi = run; have_hi = 1;
          if (run < min_hi) min_hi = run;
        end else begin
          last_lo = run;
          if (run < min_lo) min_lo = run;
          if (have_hi) begin
            if (last_hi + run < min_prd) min_prd = last_hi + run;
            if (last_hi + run > max_prd) max_prd = last_hi + run;
          end
        end
      end
      started = 1; prev = byte_clk; run = 1;
    end else begin
      run = run + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic use_a, input logic rf);
    sel_a   = use_a;
    ser_a   = use_a ? b : ~b;
    ser_b   = use_a ? ~b : b;
    reframe = rf;
    @(negedge clk);
    reframe = 1'b0;
  endtask

  task automatic send_char(input logic [BITS-1:0] d, input logic use_a,
                           input logic rf, input string req);
    for (int i = 0; i < BITS; i++) begin
      step(d[BITS-1-i], use_a, rf && (i == 0));
      if (i < BITS - 1) chk({req, " R3 no strobe"}, xfer_stb, 0);
    end
    chk({req, " R3 strobe"}, xfer_stb, 1);
    chk({req, " R3 data"}, dec_q, d);
  endtask

  task automatic settle();
    send_char(10'h2E5, 1'b1, 1'b1, "R5 settle");
    send_char(10'h1B3, 1'b1, 1'b0, "R5 settle");
  endtask

  task automatic t_reset();
    logic [BITS-1:0] d = 10'h17C;
    rst_n = 1'b0; reframe = 1'b0; sel_a = 1'b1; ser_a = 1'b0; ser_b = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 clk in reset", byte_clk, 0);
    chk("R2 stb in reset", xfer_stb, 0);
    chk("R2 data in reset", dec_q, 0);
    rst_n = 1'b1;
    for (int i = 0; i < BITS; i++) begin
      step(d[BITS-1-i], 1'b1, 1'b0);
      if (i == 0) chk("R2 first rise", byte_clk, 1);
    end
    chk("R2 first strobe", xfer_stb, 1);
    chk("R2 first char", dec_q, d);
  endtask

  task automatic t_select();
    settle();
    send_char(10'h0F3, 1'b1, 1'b0, "R1 input A");
    send_char(10'h30C, 1'b0, 1'b0, "R1 input B");
    send_char(10'h2AA, 1'b0, 1'b0, "R1 input B");
    send_char(10'h155, 1'b1, 1'b0, "R1 input A");
  endtask

  task automatic t_regular();
    logic [BITS-1:0] d = 10'h247;
    settle();
    for (int i = 0; i < BITS; i++) begin
      step(d[BITS-1-i], 1'b1, 1'b0);
      chk("R4 level", byte_clk, (i < HI) ? 1 : 0);
      if (i == 0) chk("R4 strobe ends at rise", xfer_stb, 0);
    end
    chk("R4 strobe before rise", xfer_stb, 1);
    chk("R4 data", dec_q, d);
  endtask

  task automatic t_stretch_hi(input int j);
    settle();
    for (int i = 0; i < j; i++) step(1'b0, 1'b1, 1'b0);
    send_char(10'h3C1, 1'b1, 1'b1, "R5 reframe in high");
    chk("R8 stretched high", last_hi, j + HI);
    step(1'b1, 1'b1, 1'b0);
    chk("R8 low after stretch", last_lo, LO);
  endtask

  task automatic t_stretch_lo(input int j);
    settle();
    for (int i = 0; i < HI + j; i++) step(1'b1, 1'b1, 1'b0);
    send_char(10'h0B6, 1'b1, 1'b1, "R5 reframe in low");
    step(1'b0, 1'b1, 1'b0);
    chk("R9 rise after stretch", byte_clk, 1);
    chk("R9 stretched low", last_lo, j + BITS);
  endtask

  task automatic t_suppress();
    logic [BITS-1:0] d = 10'h29D;
    settle();
    for (int i = 0; i < BITS - 1; i++) step(1'b1, 1'b1, 1'b0);
    step(d[BITS-1], 1'b1, 1'b1);
    chk("R6 no strobe for cut char", xfer_stb, 0);
    chk("R6 data held", dec_q, 10'h1B3);
    for (int i = 1; i < BITS; i++) step(d[BITS-1-i], 1'b1, 1'b0);
    chk("R6 strobe for new char", xfer_stb, 1);
    chk("R6 new char", dec_q, d);
  endtask

  task automatic t_aligned();
    logic [BITS-1:0] d = 10'h33A;
    settle();
    for (int i = 0; i < BITS; i++) begin
      step(d[BITS-1-i], 1'b0, i == 0);
      chk("R10 level", byte_clk, (i < HI) ? 1 : 0);
    end
    chk("R10 data", dec_q, d);
    step(1'b0, 1'b0, 1'b0);
    chk("R10 high", last_hi, HI);
    chk("R10 low", last_lo, LO);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_select();
    t_regular();
    t_stretch_hi(3);
    t_stretch_hi(HI);
    t_stretch_lo(2);
    t_stretch_lo(4);
    t_suppress();
    t_aligned();
    chk("R7 min high", min_hi >= HI, 1);
    chk("R7 min low", min_lo >= LO, 1);
    chk("R7 min period", min_prd >= BITS, 1);
    chk("R9 max period", max_prd <= 2 * BITS - 1, 1);
    chk("R9 longest period reached", max_prd, 2 * BITS - 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule